// File: doc/BRIEF.md
# Dual Sample-Hold Conversion Controller

This block runs two sample-and-hold channels that share one converter with a normal voltage sequence. A trigger opens a sample window of fixed length on a channel. When the window closes, the channel raises a conversion request, and an arbiter weighs that request against the normal sequence before it starts the converter. Each finished conversion is written to a fixed slot of a result buffer. The matching data-available flag is then set, and an interrupt follows if it is enabled.

In single mode, one trigger source serves both channels, and a single merged flag reports when every enabled channel has finished. In dual mode, each channel has its own trigger source and its own flag. Fast mode places channel 0 ahead of the normal sequence. The first conversion on each channel after reset only primes the hold circuit, so its result is thrown away.

Top module: `shc_ctrl`

## Requirements
- R1: After reset, flags, interrupts, overrun bits, sample windows and buffer writes are all low. The first completed conversion of each channel writes nothing and sets no flag. Later conversions on that channel are handled normally.
- R2: An accepted trigger drives that channel's sample window high for exactly SAMP_CYC cycles. The conversion request is raised when the window ends.
- R3: In dual mode, a channel 0 result goes to buffer address 23 and sets flag bit 0. A channel 1 result goes to address 24 and sets flag bit 1. The written data equals the converter data returned for that conversion.
- R4: In single mode with both channels enabled, flag bit 0 rises in the same cycle as the later of the two buffer writes. Flag bit 1 is never set in single mode.
- R5: In single mode with only one channel enabled, flag bit 0 rises in the cycle of that channel's write, and the other slot is not written.
- R6: Interrupt bit i is high exactly when flag bit i is set and interrupt enable bit i is set.
- R7: Writing 1 to a flag bit clears it. If a completion for that flag arrives in the same cycle as the clear, the flag stays set.
- R8: A trigger on an enabled channel is ignored when it comes less than the minimum spacing after the last accepted trigger. The spacing is SP_FAST cycles for channel 0 in fast mode and SP_NORM cycles otherwise. An ignored trigger sets a sticky overrun bit, which is cleared by writing 1 to it.
- R9: In fast mode, a pending channel 0 request is started ahead of a pending normal request. Otherwise, normal requests win, and sample-hold requests are started only when no normal request is pending. The conversion select code is 0 for normal, 1 for channel 0 and 2 for channel 1.
- R10: Disabling a channel while its sample window, pending request or in-flight conversion is active cancels it, and no result or flag is produced.
- R11: The single-mode source select works as follows. Code 01 uses internal trigger bit 0, code 10 uses a rising edge on external trigger 0, and codes 00 and 11 trigger nothing.
- R12: In dual mode, channel i is triggered by internal trigger bit i when its source bit is 1, and by a rising edge of external trigger i when the source bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 = dual mode, 0 = single mode |
| cfg_fast | input | 1 | Fast mode: channel 0 priority and short spacing |
| cfg_src_sel | input | 2 | Single-mode trigger source code |
| cfg_ch_en | input | 2 | Per-channel enable |
| cfg_int_sel | input | 2 | Dual-mode per-channel source: 1 internal, 0 external |
| cfg_irq_en | input | 2 | Per-flag interrupt enable |
| int_trig | input | 2 | Internal trigger pulses |
| ext_trig | input | 2 | External trigger levels (rising edge triggers) |
| flag_clr | input | 2 | Write-1-to-clear for the flags |
| ovr_clr | input | 2 | Write-1-to-clear for the overrun bits |
| norm_req | input | 1 | Normal sequence conversion request, held until granted |
| conv_data | input | DW | Converter result |
| conv_done | input | 1 | Converter finished the current conversion |
| samp_win | output | 2 | Sample window per channel |
| conv_start | output | 1 | Start pulse to the converter |
| conv_sel | output | 2 | Owner of the started conversion |
| norm_grant | output | 1 | Normal request was started |
| norm_done | output | 1 | Normal conversion finished |
| buf_we | output | 1 | Result buffer write enable |
| buf_addr | output | AW | Result buffer address |
| buf_wdata | output | DW | Result buffer write data |
| flag | output | 2 | Data-available flags |
| irq | output | 2 | Interrupt outputs |
| ovr | output | 2 | Sticky trigger overrun bits |

## Verification
The bench builds the block with a 4-cycle sample window, a normal spacing of 40 cycles and a fast spacing of 20 cycles, in place of the thousands of cycles that real timings need. With these values, overrun rejection and re-acceptance after the spacing can both be reached in a few dozen cycles. Priming, group completion, priority starvation under continuous normal traffic, and cancellation at each stage also fit into short runs. The converter model answers three cycles after a start, which makes collisions between completions and clears easy to place.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SEL_NORM = 2'd0,
    SEL_SH0  = 2'd1,
    SEL_SH1  = 2'd2,
    SEL_NONE = 2'd3
  } conv_sel_e;

  localparam logic [1:0] SRC_OFF  = 2'b00;
  localparam logic [1:0] SRC_INT  = 2'b01;
  localparam logic [1:0] SRC_EXT0 = 2'b10;
endpackage

// File: rtl/shc_trig.sv
module shc_trig #(
  parameter int SAMP_CYC = 15,
  parameter int SP_NORM  = 12500,
  parameter int SP_FAST  = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic trig,
  input  logic fast,
  input  logic busy,
  input  logic gnt,
  output logic samp_win,
  output logic pend,
  output logic acc,
  output logic rej
);
  localparam int SP_MAX = (SP_NORM > SP_FAST) ? SP_NORM : SP_FAST;
  localparam int GW = $clog2(SP_MAX + 1);
  localparam int WW = $clog2(SAMP_CYC + 1);
  localparam logic [GW-1:0] GAP_N = GW'(SP_NORM - 1);
  localparam logic [GW-1:0] GAP_F = GW'(SP_FAST - 1);
  localparam logic [WW-1:0] WIN_LEN = WW'(SAMP_CYC);

  logic [GW-1:0] gap;
  logic [WW-1:0] wcnt;

  // channel fully idle and spacing elapsed
  assign acc = trig & en & (gap == '0) & (wcnt == '0) & ~pend & ~busy;
  assign rej = trig & en & ~acc;
  assign samp_win = (wcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      wcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (acc) gap <= fast ? GAP_F : GAP_N;
      else if (gap != '0) gap <= gap - GW'(1);

      if (!en) wcnt <= '0;
      else if (acc) wcnt <= WIN_LEN;
      else if (wcnt != '0) wcnt <= wcnt - WW'(1);

      if (!en) pend <= 1'b0;
      else if (wcnt == WW'(1)) pend <= 1'b1;
      else if (gnt) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/shc_arb.sv
module shc_arb
  import shc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fast,
  input  logic      norm_req,
  input  logic [1:0] pend,
  input  logic [1:0] en,
  input  logic      conv_done,
  output logic      conv_start,
  output conv_sel_e conv_sel,
  output logic      norm_grant,
  output logic      norm_done,
  output logic [1:0] gnt,
  output logic [1:0] infl,
  output logic [1:0] cmp
);
  logic      busy;
  logic      drop;
  conv_sel_e owner;
  conv_sel_e pick;

  always_comb begin
    pick = SEL_NONE;
    if (!busy) begin
      if (fast && pend[0])  pick = SEL_SH0;
      else if (norm_req)    pick = SEL_NORM;
      else if (pend[0])     pick = SEL_SH0;
      else if (pend[1])     pick = SEL_SH1;
    end
  end

  assign gnt  = {pick == SEL_SH1, pick == SEL_SH0};
  assign infl = {busy && (owner == SEL_SH1), busy && (owner == SEL_SH0)};
  assign cmp  = {2{conv_done & ~drop}} & infl & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      drop       <= 1'b0;
      owner      <= SEL_NONE;
      conv_start <= 1'b0;
      conv_sel   <= SEL_NORM;
      norm_grant <= 1'b0;
      norm_done  <= 1'b0;
    end else begin
      conv_start <= (pick != SEL_NONE);
      norm_grant <= (pick == SEL_NORM);
      norm_done  <= busy && conv_done && (owner == SEL_NORM);
      if (pick != SEL_NONE) begin
        conv_sel <= pick;
        busy     <= 1'b1;
        owner    <= pick;
        drop     <= 1'b0;
      end else begin
        if (busy && conv_done) busy <= 1'b0;
        if (|(infl & ~en)) drop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shc_res.sv
module shc_res #(
  parameter int DW    = 12,
  parameter int AW    = 5,
  parameter int SLOT0 = 23,
  parameter int SLOT1 = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual,
  input  logic [1:0]    en,
  input  logic [1:0]    acc,
  input  logic [1:0]    cmp,
  input  logic [1:0]    flag_clr,
  input  logic [1:0]    irq_en,
  input  logic [DW-1:0] data,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_wdata,
  output logic [1:0]    flag,
  output logic [1:0]    irq
);
  localparam logic [AW-1:0] ADDR0 = AW'(SLOT0);
  localparam logic [AW-1:0] ADDR1 = AW'(SLOT1);

  logic [1:0] primed, good, wait_q, wait_n, set, flag_n;
  logic       grp_v, grp_vn, grp_done;

  // a channel's first result only primes it
  assign good     = cmp & primed;
  assign wait_n   = wait_q & en & ~cmp;
  assign grp_vn   = grp_v | (|(good & wait_q));
  assign grp_done = (wait_q != 2'b00) && (wait_n == 2'b00) && grp_vn;
  assign set      = dual ? good : {1'b0, grp_done};
  assign flag_n   = (flag & ~flag_clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 2'b00;
      wait_q    <= 2'b00;
      grp_v     <= 1'b0;
      flag      <= 2'b00;
      irq       <= 2'b00;
      buf_we    <= 1'b0;
      buf_addr  <= ADDR0;
      buf_wdata <= '0;
    end else begin
      primed <= primed | cmp;
      if (!dual && (acc != 2'b00)) begin
        wait_q <= acc;
        grp_v  <= 1'b0;
      end else begin
        wait_q <= wait_n;
        grp_v  <= (wait_n == 2'b00) ? 1'b0 : grp_vn;
      end
      flag   <= flag_n;
      irq    <= flag_n & irq_en;
      buf_we <= |good;
      if (|good) begin
        buf_addr  <= good[1] ? ADDR1 : ADDR0;
        buf_wdata <= data;
      end
    end
  end
endmodule

// File: rtl/shc_ctrl.sv
module shc_ctrl
  import shc_pkg::*;
#(
  parameter int DW       = 12,
  parameter int AW       = 5,
  parameter int SLOT0    = 23,
  parameter int SLOT1    = 24,
  parameter int SAMP_CYC = 15,
  parameter int SP_NORM  = 12500,
  parameter int SP_FAST  = 6250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dual,
  input  logic          cfg_fast,
  input  logic [1:0]    cfg_src_sel,
  input  logic [1:0]    cfg_ch_en,
  input  logic [1:0]    cfg_int_sel,
  input  logic [1:0]    cfg_irq_en,
  input  logic [1:0]    int_trig,
  input  logic [1:0]    ext_trig,
  input  logic [1:0]    flag_clr,
  input  logic [1:0]    ovr_clr,
  input  logic          norm_req,
  input  logic [DW-1:0] conv_data,
  input  logic          conv_done,
  output logic [1:0]    samp_win,
  output logic          conv_start,
  output logic [1:0]    conv_sel,
  output logic          norm_grant,
  output logic          norm_done,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_wdata,
  output logic [1:0]    flag,
  output logic [1:0]    irq,
  output logic [1:0]    ovr
);
  localparam int NCH = 2;

  logic [NCH-1:0] ext_q, ext_rise, trig, pend, acc, rej, gnt, infl, cmp;
  conv_sel_e      sel_e;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
      ovr   <= '0;
    end else begin
      ext_q <= ext_trig;
      ovr   <= (ovr & ~ovr_clr) | rej;
    end
  end

  assign ext_rise = ext_trig & ~ext_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic t;
    always_comb begin
      if (cfg_dual) begin
        t = cfg_int_sel[i] ? int_trig[i] : ext_rise[i];
      end else begin
        case (cfg_src_sel)
          SRC_INT:  t = int_trig[0];
          SRC_EXT0: t = ext_rise[0];
          default:  t = 1'b0;
        endcase
      end
    end
    assign trig[i] = t;

    shc_trig #(
      .SAMP_CYC (SAMP_CYC),
      .SP_NORM  (SP_NORM),
      .SP_FAST  (SP_FAST)
    ) u_trig (
      .clk      (clk),
      .rst      (rst),
      .en       (cfg_ch_en[i]),
      .trig     (trig[i]),
      .fast     ((i == 0) && cfg_fast),
      .busy     (infl[i]),
      .gnt      (gnt[i]),
      .samp_win (samp_win[i]),
      .pend     (pend[i]),
      .acc      (acc[i]),
      .rej      (rej[i])
    );
  end

  shc_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .fast       (cfg_fast),
    .norm_req   (norm_req),
    .pend       (pend),
    .en         (cfg_ch_en),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_sel   (sel_e),
    .norm_grant (norm_grant),
    .norm_done  (norm_done),
    .gnt        (gnt),
    .infl       (infl),
    .cmp        (cmp)
  );
  assign conv_sel = sel_e;

  shc_res #(
    .DW    (DW),
    .AW    (AW),
    .SLOT0 (SLOT0),
    .SLOT1 (SLOT1)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .dual      (cfg_dual),
    .en        (cfg_ch_en),
    .acc       (acc),
    .cmp       (cmp),
    .flag_clr  (flag_clr),
    .irq_en    (cfg_irq_en),
    .data      (conv_data),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .flag      (flag),
    .irq       (irq)
  );
endmodule

// File: rtl/shc_chk.sv
module shc_chk #(
  parameter int AW    = 5,
  parameter int SLOT0 = 23,
  parameter int SLOT1 = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_dual,
  input logic [1:0]    flag,
  input logic [1:0]    flag_clr,
  input logic [1:0]    irq,
  input logic [1:0]    ovr,
  input logic [1:0]    ovr_clr,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic          conv_start
);
  a_r3_slot_addr: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (buf_addr == AW'(SLOT0)) || (buf_addr == AW'(SLOT1)));

  a_r9_single_start: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r7_flag0_hold: assert property (@(posedge clk) disable iff (rst)
    (flag[0] && !flag_clr[0]) |=> flag[0]);

  a_r7_flag1_hold: assert property (@(posedge clk) disable iff (rst)
    (flag[1] && !flag_clr[1]) |=> flag[1]);

  a_r6_irq0_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq[0] |-> flag[0]);

  a_r6_irq1_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq[1] |-> flag[1]);

  a_r4_flag1_dual_only: assert property (@(posedge clk) disable iff (rst)
    $rose(flag[1]) |-> $past(cfg_dual));

  a_r8_ovr0_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr[0] && !ovr_clr[0]) |=> ovr[0]);
endmodule

bind shc_ctrl shc_chk #(.AW(AW), .SLOT0(SLOT0), .SLOT1(SLOT1)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_dual   (cfg_dual),
  .flag       (flag),
  .flag_clr   (flag_clr),
  .irq        (irq),
  .ovr        (ovr),
  .ovr_clr    (ovr_clr),
  .buf_we     (buf_we),
  .buf_addr   (buf_addr),
  .conv_start (conv_start)
);

// File: tb/shc_ctrl_test.sv
module shc_ctrl_test;
  localparam int DW = 12;
  localparam int AW = 5;
  localparam int W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dual = 1'b1, cfg_fast = 1'b0;
  logic [1:0] cfg_src_sel = 2'b01, cfg_ch_en = 2'b11, cfg_int_sel = 2'b11, cfg_irq_en = 2'b00;
  logic [1:0] int_trig = '0, ext_trig = '0, flag_clr = '0, ovr_clr = '0;
  logic norm_req = 1'b0, conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [1:0] samp_win, conv_sel, flag, irq, ovr;
  logic conv_start, norm_grant, norm_done, buf_we;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_wdata;

  shc_ctrl #(.DW(DW), .AW(AW), .SLOT0(23), .SLOT1(24), .SAMP_CYC(W),
             .SP_NORM(40), .SP_FAST(20)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int wr0 = 0, wr1 = 0, wc0 = 0, wc1 = 0, f0c = 0;
  int ns = 0, s0 = 0, ns_at_fall = 0, norm_at_s0 = 0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [DW-1:0] last_ret [0:3];
  logic prev_w0 = 1'b0, prev_f0 = 1'b0;
  int norm_mode = 0;
  logic [1:0] collide = 2'b00;
  bit done = 1'b0;
  int seq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (buf_we && buf_addr == 5'd23) begin wr0++; wd0 = buf_wdata; wc0 = cyc; end
      if (buf_we && buf_addr == 5'd24) begin wr1++; wd1 = buf_wdata; wc1 = cyc; end
      if (conv_start) begin
        if (conv_sel == 2'd0) ns++;
        if (conv_sel == 2'd1) begin s0++; norm_at_s0 = ns; end
      end
      if (prev_w0 && !samp_win[0]) ns_at_fall = ns;
      prev_w0 = samp_win[0];
      if (flag[0] && !prev_f0) f0c = cyc;
      prev_f0 = flag[0];
    end
  end

  // converter model: answers three cycles after a start
  initial begin
    for (int k = 0; k < 4; k++) last_ret[k] = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [1:0] s;
        s = conv_sel;
        repeat (2) @(negedge clk);
        seq++;
        conv_data = DW'(seq * 37 + 5);
        last_ret[s] = conv_data;
        conv_done = 1'b1;
        if (collide != 2'b00) flag_clr = collide;
        @(negedge clk);
        conv_done = 1'b0;
        if (collide != 2'b00) flag_clr = 2'b00;
      end
    end
  end

  // normal sequence requester: 0 idle, 1 always requesting, 2 random
  initial begin
    forever begin
      @(negedge clk);
      if (norm_mode == 1) norm_req = 1'b1;
      else if (norm_mode == 2) begin
        if (norm_req && norm_grant) norm_req = 1'b0;
        else if (!norm_req && $urandom_range(3) == 0) norm_req = 1'b1;
      end else norm_req = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_int(input logic [1:0] m);
    @(negedge clk) int_trig = m;
    @(negedge clk) int_trig = 2'b00;
  endtask

  task automatic count_win(input int ch, output int c);
    c = 0;
    for (int k = 0; k < 12; k++) begin
      if (samp_win[ch]) c++;
      @(negedge clk);
    end
  endtask

  task automatic clr_flags();
    @(negedge clk) flag_clr = 2'b11;
    @(negedge clk) flag_clr = 2'b00;
  endtask

  initial begin
    int c, a0, a1, b;
    logic [1:0] m;
    void'($urandom(32'd4242));
    wait_n(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(flag == 0 && irq == 0 && ovr == 0, "R1 reset flags", {flag, irq, ovr}, 0);
    chk(samp_win == 0 && !buf_we && !conv_start, "R1 reset outputs", {samp_win, buf_we, conv_start}, 0);

    // R1 priming + R2 window length
    pulse_int(2'b11);
    count_win(0, c);
    chk(c == W, "R2 window length", c, W);
    wait_n(40);
    chk(wr0 + wr1 == 0, "R1 first conversion discarded", wr0 + wr1, 0);
    chk(flag == 0, "R1 no flag on priming", flag, 0);

    // R3 dual independent, R6 irq masked
    pulse_int(2'b01); wait_n(40);
    chk(flag == 2'b01, "R3 flag0 only", flag, 1);
    chk(wr0 == 1 && wd0 == last_ret[1], "R3 slot 23 data", wd0, last_ret[1]);
    chk(irq == 0, "R6 irq masked", irq, 0);
    pulse_int(2'b10); wait_n(40);
    chk(flag == 2'b11, "R3 flag1", flag, 3);
    chk(wr1 == 1 && wd1 == last_ret[2], "R3 slot 24 data", wd1, last_ret[2]);
    clr_flags();
    chk(flag == 0, "R7 write-1 clear", flag, 0);

    // R6 irq enabled
    cfg_irq_en = 2'b01;
    pulse_int(2'b01); wait_n(40);
    chk(irq == 2'b01, "R6 irq0 raised", irq, 1);
    clr_flags();
    chk(irq == 0, "R6 irq follows clear", irq, 0);
    cfg_irq_en = 2'b00;

    // R4 single mode both channels
    cfg_dual = 1'b0; cfg_src_sel = 2'b01;
    a0 = wr0; a1 = wr1;
    pulse_int(2'b01); wait_n(45);
    chk(wr0 == a0 + 1 && wr1 == a1 + 1, "R4 both written", wr0 + wr1, a0 + a1 + 2);
    chk(flag == 2'b01, "R4 merged flag", flag, 1);
    chk(f0c == wc1 && wc1 > wc0, "R4 flag at later write", f0c, wc1);
    clr_flags();

    // R5 single mode one channel
    cfg_ch_en = 2'b01; a1 = wr1;
    pulse_int(2'b01); wait_n(45);
    chk(flag == 2'b01 && f0c == wc0, "R5 flag at ch0 write", f0c, wc0);
    chk(wr1 == a1, "R5 slot 24 untouched", wr1, a1);
    clr_flags();
    cfg_ch_en = 2'b11;

    // R11 source select
    cfg_src_sel = 2'b00;
    pulse_int(2'b01); count_win(0, c);
    chk(c == 0, "R11 source off", c, 0);
    cfg_src_sel = 2'b11;
    pulse_int(2'b01); count_win(0, c);
    chk(c == 0, "R11 source code 11 off", c, 0);
    cfg_src_sel = 2'b10;
    @(negedge clk) ext_trig = 2'b01;
    @(negedge clk);
    count_win(0, c);
    chk(c == W, "R11 ext0 edge window", c, W);
    wait_n(40);
    chk(flag == 2'b01, "R11 ext0 flag", flag, 1);
    ext_trig = 2'b00;
    clr_flags();

    // R12 dual source select
    cfg_dual = 1'b1; cfg_int_sel = 2'b01;
    pulse_int(2'b10); count_win(1, c);
    chk(c == 0, "R12 internal ignored on ext channel", c, 0);
    @(negedge clk) ext_trig = 2'b10;
    @(negedge clk);
    count_win(1, c);
    chk(c == W, "R12 ext1 edge window", c, W);
    wait_n(40);
    chk(flag == 2'b10, "R12 ext1 flag", flag, 2);
    ext_trig = 2'b00; cfg_int_sel = 2'b11;
    clr_flags();

    // R8 spacing and overrun
    pulse_int(2'b01); wait_n(8);
    pulse_int(2'b01);
    chk(ovr == 2'b01, "R8 early trigger overrun", ovr, 1);
    wait_n(40);
    pulse_int(2'b01); count_win(0, c);
    chk(c == W, "R8 accepted after spacing", c, W);
    chk(ovr == 2'b01, "R8 overrun sticky", ovr, 1);
    @(negedge clk) ovr_clr = 2'b01;
    @(negedge clk) ovr_clr = 2'b00;
    chk(ovr == 0, "R8 overrun clear", ovr, 0);
    wait_n(40); clr_flags();

    // R9 fast priority
    cfg_fast = 1'b1; norm_mode = 1; wait_n(10);
    a0 = s0;
    pulse_int(2'b01); wait_n(40);
    chk(s0 == a0 + 1, "R9 fast ch0 served", s0, a0 + 1);
    chk(norm_at_s0 - ns_at_fall <= 1, "R9 fast ahead of normal", norm_at_s0 - ns_at_fall, 1);
    cfg_fast = 1'b0; wait_n(5);
    a0 = s0;
    pulse_int(2'b01); wait_n(60);
    chk(s0 == a0, "R9 normal wins without fast", s0, a0);
    norm_mode = 0; wait_n(30);
    chk(s0 == a0 + 1, "R9 ch0 served when normal idle", s0, a0 + 1);
    clr_flags();

    // R10 cancel in window and in flight
    a1 = wr1;
    pulse_int(2'b10); wait_n(2);
    cfg_ch_en = 2'b01; wait_n(40);
    chk(wr1 == a1 && flag[1] == 1'b0, "R10 cancel in window", wr1, a1);
    cfg_ch_en = 2'b11; wait_n(5);
    pulse_int(2'b10);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (conv_start && conv_sel == 2'd2) break;
    end
    cfg_ch_en = 2'b01; wait_n(20);
    chk(wr1 == a1 && flag[1] == 1'b0, "R10 cancel in flight", wr1, a1);
    cfg_ch_en = 2'b11; wait_n(30);

    // R7 completion collides with clear
    a0 = wr0;
    pulse_int(2'b01); wait_n(40);
    collide = 2'b01;
    pulse_int(2'b01); wait_n(40);
    collide = 2'b00;
    chk(flag[0] == 1'b1, "R7 set wins over clear", flag[0], 1);
    chk(wr0 == a0 + 2, "R7 both written", wr0, a0 + 2);
    clr_flags();

    // constrained random: dual mode under random normal traffic
    norm_mode = 2;
    for (int it = 0; it < 20; it++) begin
      m = 2'($urandom_range(3, 1));
      cfg_fast = 1'($urandom_range(1));
      cfg_irq_en = 2'($urandom_range(3));
      a0 = wr0; a1 = wr1;
      pulse_int(m);
      b = 100 + $urandom_range(20);
      wait_n(b);
      if (m[0]) chk(wr0 == a0 + 1 && wd0 == last_ret[1], "R3 random slot 23", wd0, last_ret[1]);
      if (m[1]) chk(wr1 == a1 + 1 && wd1 == last_ret[2], "R3 random slot 24", wd1, last_ret[2]);
      chk(flag == m, "R3 random flags", flag, m);
      chk(irq == (m & cfg_irq_en), "R6 random irq", irq, m & cfg_irq_en);
      clr_flags();
    end
    norm_mode = 0;
    wait_n(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule